// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Shifter

This block turns a word that arrives in parallel into a serial bit stream. Parallel input data is first captured into a storage register when the capture strobe is asserted. A separate shift register can then be loaded from that storage, cleared, or advanced one bit toward the serial output. Each advance brings the serial input into the least significant bit. A load in the same cycle as a capture bypasses the storage register, so that both registers take the fresh input word at once.

Everything runs on one clock. The capture and shift strobes are single-cycle enables. Load and clear are active-low synchronous levels, applied in the priority clear, then load, then shift. Asserting load and clear together is illegal. The block raises an error flag for that combination and resolves it by clearing. The reset input is active low: it asserts asynchronously and releases through a two-stage synchronizer. Reset sets both registers to zero.

Top module: `capture_piso`

## Requirements
- R1: While reset is applied and after it is released, both registers hold zero: `ser_out` is 0, and a load from storage made before any capture brings only zeros out.
- R2: A cycle with `cap_stb` high copies `par_in` into the storage register, whatever the levels of `load_n`, `clear_n` and `shf_stb`.
- R3: With `load_n` low, `clear_n` high and `cap_stb` low, the shift register takes the storage contents at the next edge, and a simultaneous `shf_stb` has no effect.
- R4: With `load_n` low, `clear_n` high and `cap_stb` high, the shift register takes the current `par_in` at the same edge that stores it.
- R5: With `clear_n` low, the shift register is all zeros after the next edge, and the storage register keeps its contents unless `cap_stb` is high.
- R6: With `load_n` and `clear_n` both high and `shf_stb` high, bit n takes bit n-1 and bit 0 takes `ser_in`.
- R7: `ser_out` is bit WIDTH-1 of the shift register. After a load, that bit holds the value of `par_in[WIDTH-1]`.
- R8: `ctl_err` is high in exactly the cycles where `load_n` and `clear_n` are both low. In such a cycle clear wins, and the shift register is zero afterwards.
- R9: With `load_n` and `clear_n` high and `shf_stb` low, the shift register holds its value, whatever `ser_in` does.
- R10: While `load_n` stays low, the shift register follows the storage register or the flow-through input every cycle, and shift strobes are ignored.
- R11: After a load with `ser_in` held low, WIDTH shift strobes put bits WIDTH-1 down to 0 on `ser_out`, and further shifts give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| cap_stb | input | 1 | Capture strobe for the storage register |
| shf_stb | input | 1 | Shift strobe for the shift register |
| load_n | input | 1 | Active-low load of the shift register |
| clear_n | input | 1 | Active-low clear of the shift register |
| ser_in | input | 1 | Serial fill bit, enters at bit 0 |
| par_in | input | WIDTH | Parallel data word |
| ser_out | output | 1 | Most significant bit of the shift register |
| ctl_err | output | 1 | High while load and clear are both asserted |

## Verification
The bench builds the block with its default WIDTH of 8. At that width a full drain takes eight shifts, so every loaded word is walked out bit by bit. The whole register contents are therefore visible at `ser_out`, even the effects of clear, of a flow-through load, and of a capture made while clear is asserted. Holding load low with shift strobes and fresh captures tests the control priority against the bench's reference model on every cycle.

// File: rtl/capture_piso_pkg.sv
package capture_piso_pkg;

  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_SHIFT  = 3'd1,
    OP_LD_STO = 3'd2,
    OP_LD_DIR = 3'd3,
    OP_ZERO   = 3'd4
  } sr_op_e;

  // Priority: clear, then load (direct when capturing), then shift.
  function automatic sr_op_e pick_op(input logic load_n, input logic clear_n,
                                     input logic shf_stb, input logic cap_stb);
    sr_op_e op;
    if (!clear_n)      op = OP_ZERO;
    else if (!load_n)  op = cap_stb ? OP_LD_DIR : OP_LD_STO;
    else if (shf_stb)  op = OP_SHIFT;
    else               op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/capture_piso_rst_sync.sv
module capture_piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/capture_piso_store.sv
module capture_piso_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (cap_en) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/capture_piso_ctrl.sv
module capture_piso_ctrl
  import capture_piso_pkg::*;
(
  input  logic   load_n,
  input  logic   clear_n,
  input  logic   shf_stb,
  input  logic   cap_stb,
  output sr_op_e op,
  output logic   err
);
  always_comb begin
    op  = pick_op(load_n, clear_n, shf_stb, cap_stb);
    err = ~(load_n | clear_n);
  end
endmodule

// File: rtl/capture_piso_shreg.sv
module capture_piso_shreg
  import capture_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sr_op_e           op,
  input  logic [WIDTH-1:0] sto,
  input  logic [WIDTH-1:0] direct,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] q_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign shifted[i] = ser_in;
    end else begin : g_up
      assign shifted[i] = q[i-1];
    end
  end

  always_comb begin
    unique case (op)
      OP_ZERO:   q_d = '0;
      OP_LD_DIR: q_d = direct;
      OP_LD_STO: q_d = sto;
      OP_SHIFT:  q_d = shifted;
      default:   q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/capture_piso.sv
module capture_piso
  import capture_piso_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  logic             shf_stb,
  input  logic             load_n,
  input  logic             clear_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ctl_err
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] sh_q;
  sr_op_e           sh_op;

  capture_piso_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  capture_piso_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(cap_stb), .din(par_in), .q(store_q)
  );

  capture_piso_ctrl u_ctrl (
    .load_n(load_n), .clear_n(clear_n), .shf_stb(shf_stb), .cap_stb(cap_stb),
    .op(sh_op), .err(ctl_err)
  );

  capture_piso_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk(clk), .rst_n(rst_sync_n), .op(sh_op), .sto(store_q), .direct(par_in),
    .ser_in(ser_in), .q(sh_q)
  );

  assign ser_out = sh_q[WIDTH-1];
endmodule

// File: rtl/capture_piso_chk.sv
module capture_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             cap_stb,
  input logic             shf_stb,
  input logic             load_n,
  input logic             clear_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] sh_q,
  input logic             ser_out,
  input logic             ctl_err
);
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    cap_stb |=> store_q == $past(par_in));

  p_load_store_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!load_n && clear_n && !cap_stb) |=> sh_q == $past(store_q));

  p_flow_through_r4: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!load_n && clear_n && cap_stb) |=> sh_q == $past(par_in));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !clear_n |=> (sh_q == '0 && !ser_out));

  p_clear_keeps_store_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!clear_n && !cap_stb) |=> $stable(store_q));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (load_n && clear_n && shf_stb) |=> sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_in)});

  p_err_clears_r8: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    ctl_err |=> !ser_out && sh_q == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (load_n && clear_n && !shf_stb) |=> $stable(sh_q));
endmodule

bind capture_piso capture_piso_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .cap_stb(cap_stb),
  .shf_stb(shf_stb), .load_n(load_n), .clear_n(clear_n), .ser_in(ser_in),
  .par_in(par_in), .store_q(store_q), .sh_q(sh_q), .ser_out(ser_out),
  .ctl_err(ctl_err)
);

// File: tb/test_capture_piso.sv
module test_capture_piso;
  localparam int  W     = 8;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n, cap_stb, shf_stb, load_n, clear_n, ser_in, ser_out, ctl_err;
  logic [W-1:0] par_in;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic  q_exp[$];
  string q_tag[$];

  logic [W-1:0] m_sto, m_sr;

  always #(CLK_P/2) clk = ~clk;

  capture_piso #(.WIDTH(W)) i_capture_piso (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .shf_stb(shf_stb),
    .load_n(load_n), .clear_n(clear_n), .ser_in(ser_in), .par_in(par_in),
    .ser_out(ser_out), .ctl_err(ctl_err)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus, updates the reference model,
  // and queues the serial output expected after the edge.
  task automatic step(input logic cap, input logic shf, input logic ld_n,
                      input logic clr_n, input logic si, input logic [W-1:0] din,
                      input string tag);
    logic [W-1:0] nxt;
    @(negedge clk);
    cap_stb = cap; shf_stb = shf; load_n = ld_n; clear_n = clr_n;
    ser_in = si; par_in = din;
    #1;
    check({"R8 ctl_err ", tag}, ctl_err, !ld_n && !clr_n);
    if (!clr_n)      nxt = '0;
    else if (!ld_n)  nxt = cap ? din : m_sto;
    else if (shf)    nxt = {m_sr[W-2:0], si};
    else             nxt = m_sr;
    if (cap) m_sto = din;
    m_sr = nxt;
    q_exp.push_back(m_sr[W-1]);
    q_tag.push_back(tag);
  endtask

  task automatic drain(input int n, input logic si, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, 1'b1, si, 8'h00, tag);
  endtask

  // Monitor: compares the serial output a quarter period after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q_exp.size() > 0) check(q_tag.pop_front(), ser_out, q_exp.pop_front());
    end
  end

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cap_stb = 1'b0; shf_stb = 1'b0; load_n = 1'b1; clear_n = 1'b1;
    ser_in = 1'b0; par_in = '0;
    m_sto = '0; m_sr = '0;
    repeat (3) @(negedge clk);
    check("R1 ser_out in reset", ser_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ser_out after reset", ser_out, 1'b0);
    check("R1 ctl_err after reset", ctl_err, 1'b0);

    // R1: storage is zero after reset; load then shift in ones
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, "R1 load zero storage");
    drain(8, 1'b1, "R6 shift ones in");

    // R2/R3/R11: capture, load, drain MSB first, then zeros
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R2 capture");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R3 load overrides shift");
    drain(8, 1'b0, "R11 drain MSB first");
    drain(2, 1'b0, "R11 zeros after drain");

    // R9: idle cycles hold while ser_in toggles
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC3, "R2 capture C3");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7 load MSB 1");
    for (int i = 0; i < 3; i++)
      step(1'b0, 1'b0, 1'b1, 1'b1, i[0], 8'h00, "R9 hold");
    drain(8, 1'b1, "R9 drain after hold");

    // R2/R5: capture during clear; clear zeroes shifter, storage kept
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, "R5 clear with capture");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R5 shifted after clear");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R5 load kept storage");
    drain(8, 1'b0, "R7 drain 3C");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R3 reload 3C");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5 clear alone");
    drain(8, 1'b0, "R5 drain cleared");

    // R4: flow-through load
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h96, "R4 flow-through");
    drain(8, 1'b0, "R4 drain 96");

    // R10: load held with shift strobes and fresh captures
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R10 held load");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R10 held load");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, "R10 follow capture");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R10 held load");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE1, "R10 follow capture");
    drain(8, 1'b0, "R10 drain E1");

    // R8: illegal combination, clear wins, capture still happens
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R3 load E1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R8 both low");
    drain(8, 1'b0, "R8 drain zeros");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R2 load storage FF");
    drain(8, 1'b0, "R2 drain FF");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule